// File: doc/BRIEF.md
# Serial Link Training Controller

This block is the training controller for one end of a multi-lane point-to-point serial link. After reset it looks for a partner on each lane. It then asks the physical layer to send training patterns until every present lane reports lock. Next it settles the lane width and speed generation the two ends share, and it enters the active state. From the active state it can park the link in one of four low-power states, and each of those states has a different way back.

All inputs are abstract status flags: per-lane receiver load detect, per-lane lock, the partner's advertised width and top speed generation, a link error strobe, and requests to enter or leave low power.

The controller keeps a speed ceiling. When the active link reports an error, the ceiling drops one generation and the link retrains. At the slowest generation an error sends the link back to presence detection, and the ceiling is restored. The negotiated width and speed are shown only while the link is up.

Top module: `link_trainer`

## Requirements
- R1: While `rstN` is low the state reads Detect (code 0). `linkValid` and `sendTs` are low, and `linkWidth` and `linkGen` read zero.
- R2: In Detect (0) with no lane detected, the state stays Detect. When any lane is detected, the next state is Polling (1).
- R3: `sendTs` is high in Polling (1) and Configuration (2) and low in every other state. In Polling, when every detected lane reports lock, the next state is Configuration. Configuration always moves to Active (3) on the following edge.
- R4: If Polling does not reach lock within `POLL_CYCLES` edges of entering it, the state returns to Detect.
- R5: The width code (0 = x1, 1 = x4, 2 = x8, 3 = x16) is the largest of those widths that does not exceed the smaller of two values: the detected lane count and the partner width given by `partnerWidth` in the same code. It is latched in Configuration.
- R6: The speed generation (0 = slowest) is the smaller of `partnerGen` and an internal ceiling. The ceiling starts at `MAX_GEN` and is latched in Configuration.
- R7: A `linkErr` in Active at a generation above 0 moves to Polling and sets the ceiling to that generation minus one. At generation 0 it moves to Detect and restores the ceiling to `MAX_GEN`. An error takes priority over a low-power request.
- R8: `lpEnter` in Active moves to the state chosen by `lpTarget`: 0 gives L0s (4), 1 gives L1 (6), 2 gives L2 (7) and 3 gives L3 (8). In any other state `lpEnter` is ignored.
- R9: `lpExit` in L0s moves to the L0s-exit state (5). That state returns to Active after `L0S_EXIT_CYCLES` edges.
- R10: `lpExit` in L1 or L2 moves to Polling. `lpExit` in L3 moves to Detect.
- R11: `linkValid` is high exactly in states 3 to 8. Whenever it is low, `linkWidth` and `linkGen` read zero.
- R12: `linkErr` has no effect outside Active. For example, a link in L1 stays in L1 and keeps its width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| laneDetect | input | NUM_LANES | Per-lane receiver load detected |
| laneLock | input | NUM_LANES | Per-lane bit and symbol lock |
| partnerWidth | input | 2 | Partner's advertised width code |
| partnerGen | input | GEN_W | Partner's highest speed generation |
| linkErr | input | 1 | Link instability report |
| lpEnter | input | 1 | Request to enter a low-power state |
| lpTarget | input | 2 | Low-power state requested |
| lpExit | input | 1 | Request to leave the current low-power state |
| linkState | output | 4 | Current state code |
| linkValid | output | 1 | Width and speed outputs are meaningful |
| linkWidth | output | 2 | Negotiated width code |
| linkGen | output | GEN_W | Negotiated speed generation |
| sendTs | output | 1 | Request to transmit training patterns |

## Verification
Every state change, and every change to width, speed or valid, appears on the first clock edge that samples the causing input, because all of them come from registers. There are two timed exceptions. The Polling timeout lands on the `POLL_CYCLES`-th edge spent in Polling, and the return from L0s lands on the `L0S_EXIT_CYCLES`-th edge in the exit state. The bench changes inputs one time unit after a rising edge and advances a cycle-level reference model at that same edge. It then compares all outputs one time unit after the edge, so every expected value lines up with the register that produces it.

// File: rtl/lt_pkg.sv
package lt_pkg;

  typedef enum logic [3:0] {
    ST_DETECT = 4'd0,
    ST_POLL   = 4'd1,
    ST_CONFIG = 4'd2,
    ST_ACTIVE = 4'd3,
    ST_LPS0   = 4'd4,
    ST_LPS0X  = 4'd5,
    ST_LP1    = 4'd6,
    ST_LP2    = 4'd7,
    ST_LP3    = 4'd8
  } linkState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic runTimer;
    logic latchLink;
    logic dropGen;
    logic resetGen;
  } ctrlStrobe_t;

  // conditions reported by datapath to control
  typedef struct packed {
    logic anyDetect;
    logic allLocked;
    logic pollExpired;
    logic exitDone;
    logic genAtMin;
  } dpStatus_t;

endpackage

// File: rtl/lt_datapath.sv
module lt_datapath
  import lt_pkg::*;
#(
  parameter int NUM_LANES       = 16,
  parameter int MAX_GEN         = 4,
  parameter int GEN_W           = 3,
  parameter int POLL_CYCLES     = 64,
  parameter int L0S_EXIT_CYCLES = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_LANES-1:0] laneDetect,
  input  logic [NUM_LANES-1:0] laneLock,
  input  logic [1:0]           partnerWidth,
  input  logic [GEN_W-1:0]     partnerGen,
  input  ctrlStrobe_t          ctrl,
  output dpStatus_t            status,
  output logic [1:0]           widthCode,
  output logic [GEN_W-1:0]     genCode
);

  localparam int TMR_MAX = (POLL_CYCLES > L0S_EXIT_CYCLES) ? POLL_CYCLES : L0S_EXIT_CYCLES;
  localparam int TMR_W   = $clog2(TMR_MAX + 1);

  logic [TMR_W-1:0] timer;
  logic [GEN_W-1:0] capGen;
  logic [7:0]       detCount;
  logic [7:0]       partnerLanes;
  logic [7:0]       limitLanes;
  logic [1:0]       fitCode;
  logic [GEN_W-1:0] fitGen;

  assign detCount = 8'($countones(laneDetect));

  always_comb begin
    case (partnerWidth)
      2'd0:    partnerLanes = 8'd1;
      2'd1:    partnerLanes = 8'd4;
      2'd2:    partnerLanes = 8'd8;
      default: partnerLanes = 8'd16;
    endcase
  end

  assign limitLanes = (detCount < partnerLanes) ? detCount : partnerLanes;

  always_comb begin
    if (limitLanes >= 8'd16)     fitCode = 2'd3;
    else if (limitLanes >= 8'd8) fitCode = 2'd2;
    else if (limitLanes >= 8'd4) fitCode = 2'd1;
    else                         fitCode = 2'd0;
  end

  assign fitGen = (partnerGen < capGen) ? partnerGen : capGen;

  always_ff @(posedge clk) begin
    if (!rstN)                              timer <= '0;
    else if (!ctrl.runTimer)                timer <= '0;
    else if (timer != TMR_W'(TMR_MAX))      timer <= timer + TMR_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rstN)              capGen <= GEN_W'(MAX_GEN);
    else if (ctrl.resetGen) capGen <= GEN_W'(MAX_GEN);
    else if (ctrl.dropGen)  capGen <= genCode - GEN_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      widthCode <= '0;
      genCode   <= '0;
    end else if (ctrl.latchLink) begin
      widthCode <= fitCode;
      genCode   <= fitGen;
    end
  end

  assign status.anyDetect   = |laneDetect;
  assign status.allLocked   = (|laneDetect) && ((laneLock & laneDetect) == laneDetect);
  assign status.pollExpired = (timer == TMR_W'(POLL_CYCLES - 1));
  assign status.exitDone    = (timer == TMR_W'(L0S_EXIT_CYCLES - 1));
  assign status.genAtMin    = (genCode == '0);

  // R6
  cap_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    capGen <= GEN_W'(MAX_GEN));

  // R6
  gen_fit_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.latchLink |=> genCode <= $past(partnerGen));

  // R7
  gen_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.dropGen |=> capGen == GEN_W'($past(genCode) - GEN_W'(1)));

endmodule

// File: rtl/lt_control.sv
module lt_control
  import lt_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  dpStatus_t   status,
  input  logic        linkErr,
  input  logic        lpEnter,
  input  logic [1:0]  lpTarget,
  input  logic        lpExit,
  output ctrlStrobe_t ctrl,
  output linkState_e  state,
  output logic        sendTs,
  output logic        linkValid
);

  linkState_e stateNext;
  logic       inLowPower;

  always_comb begin
    stateNext = state;
    case (state)
      ST_DETECT: if (status.anyDetect) stateNext = ST_POLL;
      ST_POLL: begin
        if (status.allLocked)        stateNext = ST_CONFIG;
        else if (status.pollExpired) stateNext = ST_DETECT;
      end
      ST_CONFIG: stateNext = ST_ACTIVE;
      ST_ACTIVE: begin
        if (linkErr) begin
          stateNext = status.genAtMin ? ST_DETECT : ST_POLL;
        end else if (lpEnter) begin
          case (lpTarget)
            2'd0:    stateNext = ST_LPS0;
            2'd1:    stateNext = ST_LP1;
            2'd2:    stateNext = ST_LP2;
            default: stateNext = ST_LP3;
          endcase
        end
      end
      ST_LPS0:  if (lpExit) stateNext = ST_LPS0X;
      ST_LPS0X: if (status.exitDone) stateNext = ST_ACTIVE;
      ST_LP1, ST_LP2: if (lpExit) stateNext = ST_POLL;
      ST_LP3:   if (lpExit) stateNext = ST_DETECT;
      default:  stateNext = ST_DETECT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_DETECT;
    else       state <= stateNext;
  end

  assign ctrl.runTimer  = (state == ST_POLL) || (state == ST_LPS0X);
  assign ctrl.latchLink = (state == ST_CONFIG);
  assign ctrl.dropGen   = (state == ST_ACTIVE) && linkErr && !status.genAtMin;
  assign ctrl.resetGen  = (state == ST_ACTIVE) && linkErr && status.genAtMin;

  assign inLowPower = (state == ST_LPS0) || (state == ST_LPS0X) || (state == ST_LP1) ||
                      (state == ST_LP2) || (state == ST_LP3);
  assign sendTs     = (state == ST_POLL) || (state == ST_CONFIG);
  assign linkValid  = (state == ST_ACTIVE) || inLowPower;

  // R2
  detect_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DETECT) && !status.anyDetect |=> state == ST_DETECT);

  // R3
  lock_adv_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_POLL) && status.allLocked |=> state == ST_CONFIG);

  // R3
  cfg_pass_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_CONFIG) |=> state == ST_ACTIVE);

  // R8
  lp_entry_chk: assert property (@(posedge clk) disable iff (!rstN)
    inLowPower && !$past(inLowPower) |-> $past(state) == ST_ACTIVE);

  // R12
  err_ignore_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_LP1) && !lpExit |=> state == ST_LP1);

endmodule

// File: rtl/link_trainer.sv
module link_trainer
  import lt_pkg::*;
#(
  parameter int NUM_LANES       = 16,
  parameter int MAX_GEN         = 4,
  parameter int GEN_W           = 3,
  parameter int POLL_CYCLES     = 64,
  parameter int L0S_EXIT_CYCLES = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_LANES-1:0] laneDetect,
  input  logic [NUM_LANES-1:0] laneLock,
  input  logic [1:0]           partnerWidth,
  input  logic [GEN_W-1:0]     partnerGen,
  input  logic                 linkErr,
  input  logic                 lpEnter,
  input  logic [1:0]           lpTarget,
  input  logic                 lpExit,
  output logic [3:0]           linkState,
  output logic                 linkValid,
  output logic [1:0]           linkWidth,
  output logic [GEN_W-1:0]     linkGen,
  output logic                 sendTs
);

  ctrlStrobe_t      ctrl;
  dpStatus_t        status;
  linkState_e       state;
  logic [1:0]       widthCode;
  logic [GEN_W-1:0] genCode;

  lt_control uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .status    (status),
    .linkErr   (linkErr),
    .lpEnter   (lpEnter),
    .lpTarget  (lpTarget),
    .lpExit    (lpExit),
    .ctrl      (ctrl),
    .state     (state),
    .sendTs    (sendTs),
    .linkValid (linkValid)
  );

  lt_datapath #(
    .NUM_LANES       (NUM_LANES),
    .MAX_GEN         (MAX_GEN),
    .GEN_W           (GEN_W),
    .POLL_CYCLES     (POLL_CYCLES),
    .L0S_EXIT_CYCLES (L0S_EXIT_CYCLES)
  ) uDp (
    .clk          (clk),
    .rstN         (rstN),
    .laneDetect   (laneDetect),
    .laneLock     (laneLock),
    .partnerWidth (partnerWidth),
    .partnerGen   (partnerGen),
    .ctrl         (ctrl),
    .status       (status),
    .widthCode    (widthCode),
    .genCode      (genCode)
  );

  assign linkState = state;
  assign linkWidth = linkValid ? widthCode : 2'd0;
  assign linkGen   = linkValid ? genCode : '0;

  // R11
  valid_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    !linkValid |-> (linkWidth == 2'd0) && (linkGen == '0));

endmodule

// File: tb/link_trainer_test.sv
module link_trainer_test;

  localparam int CLK_PERIOD = 10;
  localparam int LANES      = 16;
  localparam int MAXG       = 4;
  localparam int GW         = 3;
  localparam int POLLN      = 10;
  localparam int EXITN      = 3;

  logic             clk = 1'b0;
  logic             rstN;
  logic [LANES-1:0] laneDetect, laneLock;
  logic [1:0]       partnerWidth, lpTarget;
  logic [GW-1:0]    partnerGen;
  logic             linkErr, lpEnter, lpExit;
  logic [3:0]       linkState;
  logic             linkValid, sendTs;
  logic [1:0]       linkWidth;
  logic [GW-1:0]    linkGen;

  int  checks = 0;
  int  failures = 0;
  bit  done = 0;
  int  mSt, mTmr, mWid, mGen, mCap;

  always #(CLK_PERIOD/2) clk = ~clk;

  link_trainer #(
    .NUM_LANES(LANES), .MAX_GEN(MAXG), .GEN_W(GW),
    .POLL_CYCLES(POLLN), .L0S_EXIT_CYCLES(EXITN)
  ) uut (
    .clk(clk), .rstN(rstN), .laneDetect(laneDetect), .laneLock(laneLock),
    .partnerWidth(partnerWidth), .partnerGen(partnerGen), .linkErr(linkErr),
    .lpEnter(lpEnter), .lpTarget(lpTarget), .lpExit(lpExit),
    .linkState(linkState), .linkValid(linkValid), .linkWidth(linkWidth),
    .linkGen(linkGen), .sendTs(sendTs)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int fitWidth(logic [LANES-1:0] det, logic [1:0] pw);
    int n = $countones(det);
    int p = (pw == 2'd0) ? 1 : (pw == 2'd1) ? 4 : (pw == 2'd2) ? 8 : 16;
    int m = (n < p) ? n : p;
    return (m >= 16) ? 3 : (m >= 8) ? 2 : (m >= 4) ? 1 : 0;
  endfunction

  function automatic string reqFor(int st);
    case (st)
      0: return "R2";
      1: return "R4";
      2: return "R5";
      3: return "R7";
      4, 5: return "R9";
      default: return "R10";
    endcase
  endfunction

  // reference model: advance one edge using current inputs
  task automatic modelStep();
    int ns = mSt;
    case (mSt)
      0: if (|laneDetect) ns = 1;
      1: begin
        if ((|laneDetect) && ((laneLock & laneDetect) == laneDetect)) ns = 2;
        else if (mTmr == POLLN - 1) ns = 0;
      end
      2: begin
        ns   = 3;
        mWid = fitWidth(laneDetect, partnerWidth);
        mGen = (int'(partnerGen) < mCap) ? int'(partnerGen) : mCap;
      end
      3: begin
        if (linkErr) begin
          if (mGen == 0) begin ns = 0; mCap = MAXG; end
          else begin ns = 1; mCap = mGen - 1; end
        end else if (lpEnter) begin
          ns = (lpTarget == 2'd0) ? 4 : (lpTarget == 2'd1) ? 6 : (lpTarget == 2'd2) ? 7 : 8;
        end
      end
      4: if (lpExit) ns = 5;
      5: if (mTmr == EXITN - 1) ns = 3;
      6, 7: if (lpExit) ns = 1;
      8: if (lpExit) ns = 0;
      default: ns = 0;
    endcase
    mTmr = (mSt == 1 || mSt == 5) ? mTmr + 1 : 0;
    mSt  = ns;
  endtask

  task automatic compareAll();
    bit v = (mSt >= 3);
    chk(linkState == 4'(mSt), reqFor(mSt), "state", linkState, mSt);
    chk(linkValid == v, "R11", "valid", linkValid, v);
    chk(linkWidth == 2'(v ? mWid : 0), "R5", "width", linkWidth, v ? mWid : 0);
    chk(linkGen == GW'(v ? mGen : 0), "R6", "gen", linkGen, v ? mGen : 0);
    chk(sendTs == (mSt == 1 || mSt == 2), "R3", "sendTs", sendTs, (mSt == 1 || mSt == 2));
  endtask

  task automatic tick();
    modelStep();
    @(posedge clk);
    #1;
    compareAll();
  endtask

  task automatic quiet();
    linkErr = 0; lpEnter = 0; lpExit = 0; lpTarget = 0;
  endtask

  initial begin
    void'($urandom(32'd2024));
    rstN = 0; laneDetect = '0; laneLock = '0; partnerWidth = 0; partnerGen = 0;
    quiet();
    mSt = 0; mTmr = 0; mWid = 0; mGen = 0; mCap = MAXG;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk(linkState == 4'd0, "R1", "state", linkState, 0);
    chk(!linkValid && !sendTs, "R1", "valid|sendTs", linkValid | sendTs, 0);
    chk(linkWidth == 0 && linkGen == 0, "R1", "width|gen", linkWidth | linkGen, 0);
    rstN = 1;

    // R2 no lane detected holds Detect
    repeat (5) tick();
    chk(linkState == 4'd0, "R2", "hold detect", linkState, 0);

    // R4 polling timeout without lock
    laneDetect = 16'h00FF; laneLock = '0;
    tick();
    chk(linkState == 4'd1, "R2", "enter poll", linkState, 1);
    laneDetect = '0;
    for (int i = 0; i < POLLN - 1; i++) tick();
    chk(linkState == 4'd1, "R4", "still poll", linkState, 1);
    lpEnter = 1;  // R8 ignored in Polling
    tick();
    chk(linkState == 4'd0, "R4", "timeout", linkState, 0);
    lpEnter = 0;

    // R3/R5/R6 full training, partner x8, gen above ceiling
    laneDetect = 16'hFFFF; laneLock = 16'hFFFF; partnerWidth = 2'd2; partnerGen = 3'd7;
    tick();
    lpEnter = 1; tick();
    chk(linkState == 4'd2, "R8", "lpEnter in poll ignored", linkState, 2);
    lpEnter = 0; tick();
    chk(linkState == 4'd3, "R3", "active", linkState, 3);
    chk(linkWidth == 2'd2, "R5", "x8", linkWidth, 2);
    chk(linkGen == 3'd4, "R6", "gen ceiling", linkGen, 4);

    // R9 L0s entry and timed exit
    lpEnter = 1; lpTarget = 0; tick(); quiet();
    chk(linkState == 4'd4 && linkValid, "R9", "L0s", linkState, 4);
    lpExit = 1; tick(); lpExit = 0;
    for (int i = 0; i < EXITN - 1; i++) tick();
    chk(linkState == 4'd5, "R9", "exit wait", linkState, 5);
    tick();
    chk(linkState == 4'd3, "R9", "back to L0", linkState, 3);

    // R7 downgrade ladder
    for (int g = 4; g > 0; g--) begin
      linkErr = 1; tick(); linkErr = 0;
      chk(linkState == 4'd1 && !linkValid && linkWidth == 0, "R7", "retrain", linkState, 1);
      tick(); tick();
      chk(linkGen == GW'(g - 1), "R7", "lower gen", linkGen, g - 1);
    end
    linkErr = 1; lpEnter = 1; tick(); quiet();
    chk(linkState == 4'd0, "R7", "gen0 error to detect", linkState, 0);
    tick(); tick(); tick();
    chk(linkGen == 3'd4, "R7", "ceiling restored", linkGen, 4);

    // R12 and R10 L1 then L3
    lpEnter = 1; lpTarget = 1; tick(); quiet();
    linkErr = 1; tick(); linkErr = 0;
    chk(linkState == 4'd6 && linkWidth == 2'd2, "R12", "err ignored in L1", linkState, 6);
    lpExit = 1; tick(); lpExit = 0;
    chk(linkState == 4'd1, "R10", "L1 exit to poll", linkState, 1);
    tick(); tick();
    lpEnter = 1; lpTarget = 3; tick(); quiet();
    lpExit = 1; laneDetect = '0; tick(); lpExit = 0;
    chk(linkState == 4'd0, "R10", "L3 exit to detect", linkState, 0);

    // R5 five lanes with x16 partner gives x4
    laneDetect = 16'h001F; laneLock = 16'h001F; partnerWidth = 2'd3; partnerGen = 3'd1;
    tick(); tick(); tick();
    chk(linkWidth == 2'd1, "R5", "5 lanes -> x4", linkWidth, 1);
    chk(linkGen == 3'd1, "R6", "partner gen", linkGen, 1);

    // constrained random
    for (int c = 0; c < 4000; c++) begin
      if ($urandom % 16 == 0) begin
        case ($urandom % 6)
          0: laneDetect = '0;
          1: laneDetect = 16'h0001;
          2: laneDetect = 16'h000F;
          3: laneDetect = 16'h00FF;
          4: laneDetect = 16'hFFFF;
          default: laneDetect = 16'($urandom);
        endcase
        partnerWidth = 2'($urandom);
        partnerGen   = 3'($urandom);
      end
      laneLock = ($urandom % 4 != 0) ? laneDetect : 16'($urandom);
      linkErr  = ($urandom % 32 == 0);
      lpEnter  = ($urandom % 10 == 0);
      lpTarget = 2'($urandom);
      lpExit   = ($urandom % 5 == 0);
      tick();
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule